// File: doc/BRIEF.md
# Modem Control and Status Unit with Internal Loopback

This unit holds the modem control bits of a 16550-style serial port and watches the four modem status inputs (clear-to-send, data-set-ready, carrier-detect, ring). It drives the four modem control outputs. It records every change on the status inputs as a sticky change flag, and it raises a pending flag for the interrupt logic while any change flag is set. The inputs are assumed to be synchronized to `clk` already.

Software writes the control byte through a write strobe. It reads the status byte combinationally through `stat_rdata`. A status read strobe clears the change flags at the next clock edge. When the loop bit is set, the control outputs are held inactive. The status byte then shows the control bits as if they were wired back to the status inputs, which lets a driver test its modem logic without external wiring. Data-path loopback and the interrupt priority logic are outside this unit.

Top module: `mdm_ctl_stat`

## Requirements
- R1: After reset, `ctl_rdata` is 0x08 (only OUT2 set). `out2_o` is 1 and `dtr_o`, `rts_o`, `out1_o` are 0. With inputs at DCD=1, RI=0, DSR=1, CTS=1, `stat_rdata` is 0xB0 and `stat_pend` is 0.
- R2: A `ctl_wr` stores `ctl_wdata[4:0]` with this layout: bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 LOOP. Bits 7:5 are discarded and read back as 0. `ctl_rdata` shows the new value one cycle after the strobe.
- R3: When LOOP is 0, `dtr_o`, `rts_o`, `out1_o` and `out2_o` equal control bits 0..3 from the cycle after the write.
- R4: Outside loopback, `stat_rdata[7:4]` holds DCD, RI, DSR, CTS (bit 7 down to bit 4), sampled one cycle after the inputs change.
- R5: A change of DCD, DSR or CTS in either direction sets its change flag (bit 3 DCD, bit 1 DSR, bit 0 CTS) at the clock edge that samples it.
- R6: Change flag bit 2 is set only when RI goes from 1 to 0. A 0-to-1 change of RI leaves it clear.
- R7: Change flags stay set until a status read. New changes are ORed into the flags already set.
- R8: `stat_rd` clears all four change flags at the next edge. A change sampled at that same edge still sets its flag.
- R9: `stat_pend` is 1 exactly when a change flag is set and LOOP is 0.
- R10: With LOOP set, all four control outputs are 0. `stat_rdata` is {OUT2, OUT1, DTR, RTS, 4'b0000}. `stat_pend` is 0, and a status read does not clear the change flags, which keep gathering external changes for use once LOOP returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| stat_rd | input | 1 | Status byte read strobe (clears change flags) |
| cts_i | input | 1 | Clear-to-send input, 1 = asserted |
| dsr_i | input | 1 | Data-set-ready input, 1 = asserted |
| dcd_i | input | 1 | Carrier-detect input, 1 = asserted |
| ri_i | input | 1 | Ring input, 1 = asserted |
| ctl_rdata | output | 8 | Control byte read data |
| stat_rdata | output | 8 | Status byte read data |
| dtr_o | output | 1 | Data-terminal-ready output, 1 = asserted |
| rts_o | output | 1 | Request-to-send output, 1 = asserted |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| stat_pend | output | 1 | Modem status change pending |

## Verification
Every result is registered exactly once. A control write, an input change or a read-clear therefore shows on the outputs one clock after the edge that samples it, and read data is combinational from the current registers. The bench drives stimulus on the falling edge and checks at the next falling edge, after the single rising edge in between. Read data is sampled while the read strobe is high, before that edge. The read/change collision and RI rising against falling are each checked in the cycle they take effect.

// File: rtl/mdm_pkg.sv
// Package: shared field positions and types for the modem control/status unit.
// Assumes: status nibble order DCD(3) RI(2) DSR(1) CTS(0); control byte order below.
package mdm_pkg;

    localparam int CTL_W   = 5;
    localparam int ST_W    = 4;
    localparam int BYTE_W  = 8;

    localparam int ST_CTS  = 0;
    localparam int ST_DSR  = 1;
    localparam int ST_RI   = 2;
    localparam int ST_DCD  = 3;

    localparam logic [ST_W-1:0]  ST_RST  = 4'b1011;
    localparam logic [CTL_W-1:0] CTL_RST = 5'b01000;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctl_t;

endpackage

// File: rtl/mdm_ctl_reg.sv
// Module: control register holding DTR, RTS, OUT1, OUT2 and LOOP.
// Assumes: write data low bits carry the fields; upper bits are discarded.
module mdm_ctl_reg
    import mdm_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output ctl_t          ctl_q
);

    localparam int KEEP = CTL_W;

    // Store the low control bits on a write, reset to OUT2 only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= ctl_t'(CTL_RST);
        else if (wr_i)
            ctl_q <= ctl_t'(wdata_i[KEEP-1:0]);
    end

    // R2
    ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (ctl_q == ctl_t'($past(wdata_i[KEEP-1:0]))));

endmodule

// File: rtl/mdm_delta_trk.sv
// Module: samples the status inputs and accumulates sticky change flags.
// Assumes: inputs already synchronized; the RI lane flags only a falling change.
module mdm_delta_trk
    import mdm_pkg::*;
#(
    parameter int              N      = ST_W,
    parameter int              RI_IDX = ST_RI,
    parameter logic [N-1:0]    RST_ST = ST_RST
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    input  logic         clr_i,
    output logic [N-1:0] st_q,
    output logic [N-1:0] dlt_q
);

    logic [N-1:0] chg;
    logic [N-1:0] dlt_d;

    // Per-lane change detect; the ring lane keeps only the 1-to-0 edge.
    for (genvar i = 0; i < N; i++) begin : g_lane
        if (i == RI_IDX) begin : g_trail
            assign chg[i] = st_q[i] & ~lines_i[i];
        end else begin : g_any
            assign chg[i] = st_q[i] ^ lines_i[i];
        end
    end

    // Next flags: clear on read, then OR in changes sampled this cycle.
    always_comb begin
        dlt_d = (clr_i ? '0 : dlt_q) | chg;
    end

    // Register sampled status and change flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RST_ST;
            dlt_q <= '0;
        end else begin
            st_q  <= lines_i;
            dlt_q <= dlt_d;
        end
    end

    // R4
    st_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q == $past(lines_i)));

    // R6
    ri_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !st_q[RI_IDX]) |=> !dlt_q[RI_IDX]);

    // R7
    dlt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((dlt_q & $past(dlt_q)) == $past(dlt_q)));

    // R8
    dlt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (lines_i == st_q)) |=> (dlt_q == '0));

endmodule

// File: rtl/mdm_view.sv
// Module: forms read data, external pins and pending flag, applying loopback.
// Assumes: purely combinational; all state lives in the register modules.
module mdm_view
    import mdm_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int N  = ST_W
) (
    input  ctl_t          ctl_i,
    input  logic [N-1:0]  st_i,
    input  logic [N-1:0]  dlt_i,
    input  logic          rd_i,
    output logic [DW-1:0] ctl_rdata,
    output logic [DW-1:0] stat_rdata,
    output logic          clr_o,
    output logic          dtr_o,
    output logic          rts_o,
    output logic          out1_o,
    output logic          out2_o,
    output logic          pend_o
);

    localparam int PAD = DW - CTL_W;

    logic [N-1:0] loop_st;

    // Map control bits onto the status lanes as if wired back.
    always_comb begin
        loop_st          = '0;
        loop_st[ST_DCD]  = ctl_i.out2;
        loop_st[ST_RI]   = ctl_i.out1;
        loop_st[ST_DSR]  = ctl_i.dtr;
        loop_st[ST_CTS]  = ctl_i.rts;
    end

    // Select status view and gate read-clear and pending by loop mode.
    always_comb begin
        ctl_rdata = {{PAD{1'b0}}, ctl_i};
        if (ctl_i.loop) begin
            stat_rdata = {loop_st, {N{1'b0}}};
            clr_o      = 1'b0;
            pend_o     = 1'b0;
        end else begin
            stat_rdata = {st_i, dlt_i};
            clr_o      = rd_i;
            pend_o     = |dlt_i;
        end
    end

    // Drive pins, held inactive while looping back.
    always_comb begin
        dtr_o  = ctl_i.dtr  & ~ctl_i.loop;
        rts_o  = ctl_i.rts  & ~ctl_i.loop;
        out1_o = ctl_i.out1 & ~ctl_i.loop;
        out2_o = ctl_i.out2 & ~ctl_i.loop;
    end

endmodule

// File: rtl/mdm_ctl_stat.sv
// Module: top of the modem control/status unit.
// Assumes: status inputs synchronized to clk; synchronous active-low reset.
module mdm_ctl_stat
    import mdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic       stat_rd,
    input  logic       cts_i,
    input  logic       dsr_i,
    input  logic       dcd_i,
    input  logic       ri_i,
    output logic [7:0] ctl_rdata,
    output logic [7:0] stat_rdata,
    output logic       dtr_o,
    output logic       rts_o,
    output logic       out1_o,
    output logic       out2_o,
    output logic       stat_pend
);

    ctl_t            ctl_q;
    logic [ST_W-1:0] lines;
    logic [ST_W-1:0] st_q;
    logic [ST_W-1:0] dlt_q;
    logic            clr;

    // Gather status inputs into lane order.
    always_comb begin
        lines         = '0;
        lines[ST_CTS] = cts_i;
        lines[ST_DSR] = dsr_i;
        lines[ST_RI]  = ri_i;
        lines[ST_DCD] = dcd_i;
    end

    mdm_ctl_reg #(.DW(BYTE_W)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (ctl_wr),
        .wdata_i(ctl_wdata),
        .ctl_q  (ctl_q)
    );

    mdm_delta_trk #(.N(ST_W), .RI_IDX(ST_RI), .RST_ST(ST_RST)) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines_i(lines),
        .clr_i  (clr),
        .st_q   (st_q),
        .dlt_q  (dlt_q)
    );

    mdm_view #(.DW(BYTE_W), .N(ST_W)) u_view (
        .ctl_i     (ctl_q),
        .st_i      (st_q),
        .dlt_i     (dlt_q),
        .rd_i      (stat_rd),
        .ctl_rdata (ctl_rdata),
        .stat_rdata(stat_rdata),
        .clr_o     (clr),
        .dtr_o     (dtr_o),
        .rts_o     (rts_o),
        .out1_o    (out1_o),
        .out2_o    (out2_o),
        .pend_o    (stat_pend)
    );

    // R3
    pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata[4]) |=> ({out2_o, out1_o, rts_o, dtr_o} == $past(ctl_wdata[3:0])));

    // R10
    loop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ctl_rdata[4]) |=> ((dlt_q & $past(dlt_q)) == $past(dlt_q)));

    // R10
    loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[4] |-> !(dtr_o || rts_o || out1_o || out2_o || stat_pend));

endmodule

// File: tb/sim_mdm_ctl_stat.sv
module sim_mdm_ctl_stat;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       stat_rd = 1'b0;
    logic       cts_i = 1'b1, dsr_i = 1'b1, dcd_i = 1'b1, ri_i = 1'b0;
    logic [7:0] ctl_rdata, stat_rdata;
    logic       dtr_o, rts_o, out1_o, out2_o, stat_pend;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mdm_ctl_stat u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .stat_rd(stat_rd), .cts_i(cts_i), .dsr_i(dsr_i), .dcd_i(dcd_i), .ri_i(ri_i),
        .ctl_rdata(ctl_rdata), .stat_rdata(stat_rdata), .dtr_o(dtr_o), .rts_o(rts_o),
        .out1_o(out1_o), .out2_o(out2_o), .stat_pend(stat_pend)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        step();
        ctl_wr = 1'b0;
    endtask

    task automatic rd_stat(input string req, input logic [7:0] exp);
        stat_rd = 1'b1;
        #1 chk(req, stat_rdata, exp);
        step();
        stat_rd = 1'b0;
    endtask

    task automatic pins(input string req, input logic [3:0] exp);
        chk(req, {4'h0, out2_o, out1_o, rts_o, dtr_o}, {4'h0, exp});
    endtask

    task automatic t_reset();
        chk("R1 ctl", ctl_rdata, 8'h08);
        chk("R1 stat", stat_rdata, 8'hB0);
        pins("R1 pins", 4'b1000);
        chk("R1 pend", {7'h0, stat_pend}, 8'h00);
    endtask

    task automatic t_ctl();
        wr_ctl(8'hEF);
        chk("R2 upper bits dropped", ctl_rdata, 8'h0F);
        pins("R3 all on", 4'b1111);
        wr_ctl(8'h05);
        chk("R2 ctl", ctl_rdata, 8'h05);
        pins("R3 dtr out1", 4'b0101);
    endtask

    task automatic t_delta();
        cts_i = 1'b0; step();
        chk("R5 cts fall", stat_rdata, 8'hA1);
        chk("R9 pend", {7'h0, stat_pend}, 8'h01);
        rd_stat("R4 read", 8'hA1);
        chk("R8 cleared", stat_rdata, 8'hA0);
        chk("R9 pend low", {7'h0, stat_pend}, 8'h00);
        dsr_i = 1'b0; dcd_i = 1'b0; step();
        chk("R5 dsr dcd", stat_rdata, 8'h0A);
        rd_stat("R4 read2", 8'h0A);
        dcd_i = 1'b1; dsr_i = 1'b1; cts_i = 1'b1; step();
        chk("R5 rising", stat_rdata, 8'hBB);
        rd_stat("R8 read3", 8'hBB);
        chk("R8 cleared3", stat_rdata, 8'hB0);
    endtask

    task automatic t_ri();
        ri_i = 1'b1; step();
        chk("R6 ri rise no flag", stat_rdata, 8'hF0);
        chk("R6 pend", {7'h0, stat_pend}, 8'h00);
        ri_i = 1'b0; step();
        chk("R6 ri fall flag", stat_rdata, 8'hB4);
        rd_stat("R6 read", 8'hB4);
    endtask

    task automatic t_sticky();
        cts_i = 1'b0; step();
        chk("R7 first", stat_rdata, 8'hA1);
        cts_i = 1'b1; step();
        chk("R7 sticky", stat_rdata, 8'hB1);
        rd_stat("R7 read", 8'hB1);
    endtask

    task automatic t_race();
        stat_rd = 1'b1; cts_i = 1'b0;
        #1 chk("R8 race before", stat_rdata, 8'hB0);
        step();
        stat_rd = 1'b0;
        chk("R8 change survives clear", stat_rdata, 8'hA1);
        rd_stat("R8 read", 8'hA1);
        cts_i = 1'b1; step();
        rd_stat("R8 read2", 8'hB1);
    endtask

    task automatic t_loop();
        wr_ctl(8'h1A);
        pins("R10 pins off", 4'b0000);
        chk("R10 view", stat_rdata, 8'h90);
        cts_i = 1'b0; step();
        chk("R10 ext hidden", stat_rdata, 8'h90);
        chk("R10 pend masked", {7'h0, stat_pend}, 8'h00);
        rd_stat("R10 loop read", 8'h90);
        wr_ctl(8'h15);
        chk("R10 view2", stat_rdata, 8'h60);
        wr_ctl(8'h08);
        pins("R3 after loop", 4'b1000);
        chk("R10 flag kept", stat_rdata, 8'hA1);
        chk("R9 pend back", {7'h0, stat_pend}, 8'h01);
        rd_stat("R10 read", 8'hA1);
        cts_i = 1'b1; step();
        rd_stat("R10 restore", 8'hB1);
    endtask

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_ctl();
        t_delta();
        t_ri();
        t_sticky();
        t_race();
        t_loop();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule